// File: doc/BRIEF.md
# Enhanced Parallel Port Host Cycle Engine

This block sits between a host register bus and a bidirectional parallel peripheral link. The host talks to it through a small window of byte offsets: a status register, a control register, an address-cycle register and a data-cycle register. An access to either cycle register runs a strobe/wait handshake with the peripheral, but only if the stored control bits hold the exact pattern for that direction. Otherwise the access is dropped, and a read returns all ones.

A handshake that the peripheral does not complete within a programmable number of clocks ends the access and sets a sticky timeout flag. Software sees the flag as status bit 0 and clears it by writing a 1 to that bit. Data-cycle accesses may be 1, 2 or 4 bytes wide. They are broken into byte cycles, least significant byte first.

The host side is a request channel and a response channel, each with valid/ready. A request is taken only when `req_ready` is high. `req_ready` stays low from acceptance until the response has been taken. Every access, read or write, returns one response. `rsp_valid` and `rsp_rdata` are held, unchanged, for as long as `rsp_ready` is low.

Top module: `epp_host_engine`

## Requirements
- R1: After reset, control reads 0x0C, status reads 0x01, both strobes and nWrite are high, `pp_dir` is 0 and `pp_data_oe` is 1.
- R2: A write to offset 3 or 4 runs byte cycles only when {control[5], control[3:0]} equals 5'b00100; bit 4 of control does not matter. Otherwise no strobe falls and no byte reaches the peripheral.
- R3: A read of offset 3 or 4 runs only when {control[5], control[3:0]} equals 5'b10100. Otherwise no strobe falls and the response is all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF, with the upper bits zero.
- R4: An offset-3 access uses `pp_naddrstb` and an offset-4 access uses `pp_ndatastb`; the two strobes are never low together. For a write, nWrite is low and the byte is held on `pp_data_o`. For a read, nWrite stays high and the byte is captured from `pp_data_i`. Each byte cycle runs as follows: the strobe goes low, the engine waits for nWait high, the strobe goes high, and the engine waits for nWait low.
- R5: If nWait does not reach the awaited level within TMO_CYCLES clocks in either wait phase, the access ends at once. The timeout flag is set, the remaining bytes are abandoned, and read lanes with no completed byte return 0xFF.
- R6: Status bit 0 reflects the timeout flag. A status write with bit 0 = 1 clears the flag, and a status write with bit 0 = 0 leaves it unchanged.
- R7: `req_size` selects the width of an offset-4 access: 0 for 1 byte, 1 for 2 bytes, 2 or 3 for 4 bytes. Bytes are transferred in order from lane 0 (bits 7:0) upward. Offset 3 always transfers one byte.
- R8: A control write (offset 2) that changes bit 5 drives the new value onto `pp_dir` one clock before `pp_ctl` shows the new bits[3:0]. `pp_data_oe` is always the inverse of `pp_dir`, and nWrite is low only while `pp_dir` is 0.
- R9: `req_ready` is low from acceptance until the response is taken, including while any strobe is low. `rsp_valid` and `rsp_rdata` hold steady while `rsp_ready` is low.
- R10: Writes to offsets 0, 5, 6 and 7 change nothing, and reads of those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Engine can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 3 | Register offset |
| req_size | input | 2 | Data-cycle width code |
| req_wdata | input | 8*DATA_BYTES | Write data, lane 0 in bits 7:0 |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 8*DATA_BYTES | Read data (0 for writes) |
| pp_data_o | output | 8 | Byte driven to the peripheral |
| pp_data_i | input | 8 | Byte from the peripheral |
| pp_data_oe | output | 1 | Drive enable for the data lines |
| pp_dir | output | 1 | Data-line direction, 1 = peripheral drives |
| pp_ctl | output | 4 | Control line levels, control[3:0] |
| pp_nwrite | output | 1 | Active-low write indicator |
| pp_naddrstb | output | 1 | Active-low address strobe |
| pp_ndatastb | output | 1 | Active-low data strobe |
| pp_nwait | input | 1 | Peripheral wait/acknowledge |

## Verification
The bench builds the block with TMO_CYCLES = 12 and DATA_BYTES = 4, and its peripheral model answers each phase after two clocks. The short timeout lets the bench reach both timeout phases in a few dozen clocks: the peripheral that never raises nWait, and the one that never lowers it. The 4-byte width exercises every lane, including a 4-byte access that is abandoned after its first byte.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;
  localparam logic [2:0] OFF_STATUS  = 3'd1;
  localparam logic [2:0] OFF_CONTROL = 3'd2;
  localparam logic [2:0] OFF_EADDR   = 3'd3;
  localparam logic [2:0] OFF_EDATA   = 3'd4;

  localparam logic [5:0] CTL_RESET = 6'h0C;
  // {dir, ctl[3:0]} patterns that open a cycle
  localparam logic [4:0] GATE_WR = 5'b0_0100;
  localparam logic [4:0] GATE_RD = 5'b1_0100;

  typedef enum logic [2:0] {AC_IDLE, AC_CTL, AC_LAUNCH, AC_WAIT, AC_RSP} acc_state_e;
  typedef enum logic [1:0] {HS_IDLE, HS_ASSERT, HS_RELEASE} hs_state_e;

  function automatic logic gate_open(input logic [5:0] ctl, input logic rd);
    return {ctl[5], ctl[3:0]} == (rd ? GATE_RD : GATE_WR);
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/epp_port_regs.sv
module epp_port_regs
  import epp_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [5:0] ctl_wdata,
  input  logic       dir_we,
  input  logic       dir_wdata,
  input  logic       tmo_set,
  input  logic       tmo_clr,
  output logic [5:0] ctl_q,
  output logic       dir_q,
  output logic       tmo_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
      dir_q <= CTL_RESET[5];
      tmo_q <= 1'b1;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      if (dir_we) dir_q <= dir_wdata;
      if (tmo_set)      tmo_q <= 1'b1;
      else if (tmo_clr) tmo_q <= 1'b0;
    end
  end

  // R6: flag only drops on an explicit clear
  a_r6_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q && !tmo_clr |=> tmo_q);

  // R8: direction leads the control bits by one clock
  a_r8_dir_leads: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> (dir_q != ctl_q[5]));
endmodule

// File: rtl/epp_strobe_engine.sv
module epp_strobe_engine
  import epp_host_pkg::*;
#(
  parameter int TMO_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_addr,
  input  logic       is_read,
  input  logic [7:0] wbyte,
  output logic       done,
  output logic       err,
  output logic [7:0] rbyte,
  input  logic       pp_nwait,
  input  logic [7:0] pp_data_i,
  output logic [7:0] pp_data_o,
  output logic       pp_nwrite,
  output logic       pp_naddrstb,
  output logic       pp_ndatastb
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYCLES - 1);

  hs_state_e      st_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= HS_IDLE;
      cnt_q       <= '0;
      pp_nwrite   <= 1'b1;
      pp_naddrstb <= 1'b1;
      pp_ndatastb <= 1'b1;
      pp_data_o   <= '0;
      rbyte       <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st_q)
        HS_IDLE: begin
          if (start) begin
            pp_nwrite   <= is_read;
            pp_naddrstb <= !is_addr;
            pp_ndatastb <= is_addr;
            pp_data_o   <= wbyte;
            cnt_q       <= '0;
            st_q        <= HS_ASSERT;
          end
        end
        HS_ASSERT: begin
          if (pp_nwait) begin
            rbyte       <= pp_data_i;
            pp_naddrstb <= 1'b1;
            pp_ndatastb <= 1'b1;
            cnt_q       <= '0;
            st_q        <= HS_RELEASE;
          end else if (cnt_q == CNT_LAST) begin
            pp_naddrstb <= 1'b1;
            pp_ndatastb <= 1'b1;
            pp_nwrite   <= 1'b1;
            done        <= 1'b1;
            err         <= 1'b1;
            st_q        <= HS_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        HS_RELEASE: begin
          if (!pp_nwait) begin
            pp_nwrite <= 1'b1;
            done      <= 1'b1;
            st_q      <= HS_IDLE;
          end else if (cnt_q == CNT_LAST) begin
            pp_nwrite <= 1'b1;
            done      <= 1'b1;
            err       <= 1'b1;
            st_q      <= HS_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= HS_IDLE;
      endcase
    end
  end

  // R4: never both strobes active
  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pp_naddrstb && !pp_ndatastb));

  // R4: written byte holds while nWrite stays low
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!pp_nwrite && $past(!pp_nwrite)) |-> $stable(pp_data_o));
endmodule

// File: rtl/epp_access_ctrl.sv
module epp_access_ctrl
  import epp_host_pkg::*;
#(
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [2:0]              req_offset,
  input  logic [1:0]              req_size,
  input  logic [8*DATA_BYTES-1:0] req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [8*DATA_BYTES-1:0] rsp_rdata,
  input  logic [5:0]              ctl_q,
  input  logic                    tmo_q,
  output logic                    ctl_we,
  output logic [5:0]              ctl_wdata,
  output logic                    dir_we,
  output logic                    dir_wdata,
  output logic                    tmo_set,
  output logic                    tmo_clr,
  output logic                    hs_start,
  output logic                    hs_is_addr,
  output logic                    hs_is_read,
  output logic [7:0]              hs_wbyte,
  input  logic                    hs_done,
  input  logic                    hs_err,
  input  logic [7:0]              hs_rbyte
);
  localparam int DW = 8 * DATA_BYTES;
  localparam int IW = $clog2(DATA_BYTES) + 1;

  function automatic logic [DW-1:0] lane_ones(input logic [IW-1:0] nb);
    logic [DW-1:0] r;
    r = '0;
    for (int k = 0; k < DATA_BYTES; k++)
      if (k < int'(nb)) r[k*8 +: 8] = 8'hFF;
    return r;
  endfunction

  acc_state_e     st_q;
  logic           wr_q;
  logic [2:0]     off_q;
  logic [DW-1:0]  data_q;
  logic [DW-1:0]  rdata_q;
  logic [IW-1:0]  nb_q;
  logic [IW-1:0]  idx_q;
  logic           accept;
  logic [IW-1:0]  req_nb;
  logic           ctl_wr_req;

  assign req_ready  = (st_q == AC_IDLE);
  assign rsp_valid  = (st_q == AC_RSP);
  assign rsp_rdata  = rdata_q;
  assign accept     = req_valid && req_ready;
  assign req_nb     = (req_offset == OFF_EDATA) ? IW'(size_bytes(req_size)) : IW'(1);
  assign ctl_wr_req = accept && req_write && (req_offset == OFF_CONTROL);

  assign dir_we    = ctl_wr_req && (req_wdata[5] != ctl_q[5]);
  assign dir_wdata = req_wdata[5];
  assign ctl_we    = (ctl_wr_req && (req_wdata[5] == ctl_q[5])) || (st_q == AC_CTL);
  assign ctl_wdata = (st_q == AC_CTL) ? data_q[5:0] : req_wdata[5:0];
  assign tmo_clr   = accept && req_write && (req_offset == OFF_STATUS) && req_wdata[0];
  assign tmo_set   = (st_q == AC_WAIT) && hs_done && hs_err;

  assign hs_start   = (st_q == AC_LAUNCH);
  assign hs_is_addr = (off_q == OFF_EADDR);
  assign hs_is_read = !wr_q;
  assign hs_wbyte   = data_q[8*idx_q +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= AC_IDLE;
      wr_q    <= 1'b0;
      off_q   <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      nb_q    <= IW'(1);
      idx_q   <= '0;
    end else begin
      case (st_q)
        AC_IDLE: begin
          if (accept) begin
            wr_q    <= req_write;
            off_q   <= req_offset;
            data_q  <= req_wdata;
            nb_q    <= req_nb;
            idx_q   <= '0;
            rdata_q <= '0;
            case (req_offset)
              OFF_STATUS: begin
                if (!req_write) rdata_q <= DW'(tmo_q);
                st_q <= AC_RSP;
              end
              OFF_CONTROL: begin
                if (req_write) begin
                  st_q <= (req_wdata[5] != ctl_q[5]) ? AC_CTL : AC_RSP;
                end else begin
                  rdata_q <= DW'(ctl_q);
                  st_q    <= AC_RSP;
                end
              end
              OFF_EADDR, OFF_EDATA: begin
                if (!req_write) rdata_q <= lane_ones(req_nb);
                st_q <= gate_open(ctl_q, !req_write) ? AC_LAUNCH : AC_RSP;
              end
              default: st_q <= AC_RSP;
            endcase
          end
        end
        AC_CTL:    st_q <= AC_RSP;
        AC_LAUNCH: st_q <= AC_WAIT;
        AC_WAIT: begin
          if (hs_done) begin
            if (hs_err) begin
              st_q <= AC_RSP;
            end else begin
              if (!wr_q) rdata_q[8*idx_q +: 8] <= hs_rbyte;
              if (idx_q == nb_q - IW'(1)) begin
                st_q <= AC_RSP;
              end else begin
                idx_q <= idx_q + IW'(1);
                st_q  <= AC_LAUNCH;
              end
            end
          end
        end
        AC_RSP:  if (rsp_ready) st_q <= AC_IDLE;
        default: st_q <= AC_IDLE;
      endcase
    end
  end

  // R9: a pending response holds still
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
endmodule

// File: rtl/epp_host_engine.sv
module epp_host_engine
  import epp_host_pkg::*;
#(
  parameter int TMO_CYCLES = 1000,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [2:0]              req_offset,
  input  logic [1:0]              req_size,
  input  logic [8*DATA_BYTES-1:0] req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [8*DATA_BYTES-1:0] rsp_rdata,
  output logic [7:0]              pp_data_o,
  input  logic [7:0]              pp_data_i,
  output logic                    pp_data_oe,
  output logic                    pp_dir,
  output logic [3:0]              pp_ctl,
  output logic                    pp_nwrite,
  output logic                    pp_naddrstb,
  output logic                    pp_ndatastb,
  input  logic                    pp_nwait
);
  logic [5:0] ctl_q;
  logic       dir_q, tmo_q;
  logic       ctl_we, dir_we, dir_wdata, tmo_set, tmo_clr;
  logic [5:0] ctl_wdata;
  logic       hs_start, hs_is_addr, hs_is_read, hs_done, hs_err;
  logic [7:0] hs_wbyte, hs_rbyte;

  epp_port_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dir_we(dir_we), .dir_wdata(dir_wdata),
    .tmo_set(tmo_set), .tmo_clr(tmo_clr),
    .ctl_q(ctl_q), .dir_q(dir_q), .tmo_q(tmo_q)
  );

  epp_access_ctrl #(.DATA_BYTES(DATA_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ctl_q(ctl_q), .tmo_q(tmo_q),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dir_we(dir_we), .dir_wdata(dir_wdata),
    .tmo_set(tmo_set), .tmo_clr(tmo_clr),
    .hs_start(hs_start), .hs_is_addr(hs_is_addr), .hs_is_read(hs_is_read),
    .hs_wbyte(hs_wbyte), .hs_done(hs_done), .hs_err(hs_err), .hs_rbyte(hs_rbyte)
  );

  epp_strobe_engine #(.TMO_CYCLES(TMO_CYCLES)) u_hs (
    .clk(clk), .rst_n(rst_n),
    .start(hs_start), .is_addr(hs_is_addr), .is_read(hs_is_read), .wbyte(hs_wbyte),
    .done(hs_done), .err(hs_err), .rbyte(hs_rbyte),
    .pp_nwait(pp_nwait), .pp_data_i(pp_data_i), .pp_data_o(pp_data_o),
    .pp_nwrite(pp_nwrite), .pp_naddrstb(pp_naddrstb), .pp_ndatastb(pp_ndatastb)
  );

  assign pp_dir     = dir_q;
  assign pp_data_oe = !dir_q;
  assign pp_ctl     = ctl_q[3:0];

  // R2: a write cycle starts only under the write pattern
  a_r2_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pp_nwrite) |-> ({ctl_q[5], ctl_q[3:0]} == GATE_WR));

  // R3: a read strobe starts only under the read pattern
  a_r3_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pp_naddrstb && pp_ndatastb) && pp_nwrite) |-> ({ctl_q[5], ctl_q[3:0]} == GATE_RD));

  // R9: host is held while a strobe is active
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pp_naddrstb || !pp_ndatastb) |-> !req_ready);
endmodule

// File: tb/sim_epp_host_engine.sv
`timescale 1ns/1ps
module sim_epp_host_engine;
  localparam int TMO = 12;
  localparam int DLY = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [2:0]  req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  pp_data_o, pp_data_i;
  logic        pp_data_oe, pp_dir, pp_nwrite, pp_naddrstb, pp_ndatastb;
  logic [3:0]  pp_ctl;
  logic        nwait;

  int n_chk = 0, n_fail = 0;
  int mode = 0;          // 0 normal, 1 never raise, 2 never lower
  int pcnt, n_stb;
  logic [7:0] rd_idx;
  logic       last_rd, stb_prev, stb_low;
  logic [8:0] wq[$];     // {is_addr, byte}

  always #2.5 clk = ~clk;

  epp_host_engine #(.TMO_CYCLES(TMO), .DATA_BYTES(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pp_data_o(pp_data_o), .pp_data_i(pp_data_i), .pp_data_oe(pp_data_oe),
    .pp_dir(pp_dir), .pp_ctl(pp_ctl), .pp_nwrite(pp_nwrite),
    .pp_naddrstb(pp_naddrstb), .pp_ndatastb(pp_ndatastb), .pp_nwait(nwait)
  );

  assign pp_data_i = 8'hA0 + rd_idx;
  assign stb_low   = !pp_naddrstb || !pp_ndatastb;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural peripheral
  always @(posedge clk) begin
    if (!rst_n) begin
      nwait <= 1'b0; pcnt <= 0; rd_idx <= '0; last_rd <= 1'b0; stb_prev <= 1'b0; n_stb <= 0;
    end else begin
      if (stb_low) begin
        if (!nwait && mode != 1) begin
          if (pcnt >= DLY) begin
            nwait <= 1'b1; pcnt <= 0; last_rd <= pp_nwrite;
            if (!pp_nwrite) wq.push_back({!pp_naddrstb, pp_data_o});
          end else pcnt <= pcnt + 1;
        end
      end else if (nwait && mode != 2) begin
        if (pcnt >= DLY) begin
          nwait <= 1'b0; pcnt <= 0;
          if (last_rd) rd_idx <= rd_idx + 8'd1;
          last_rd <= 1'b0;
        end else pcnt <= pcnt + 1;
      end
      stb_prev <= stb_low;
      if (stb_low && !stb_prev) n_stb <= n_stb + 1;
    end
  end

  // per-clock protocol comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(!pp_naddrstb && !pp_ndatastb), "R4 strobes exclusive", {pp_naddrstb, pp_ndatastb}, 32'h1);
      chk(pp_nwrite || !pp_dir, "R8 nwrite low needs dir 0", pp_dir, 32'h0);
      chk(!stb_low || !req_ready, "R9 ready low during strobe", req_ready, 32'h0);
      chk(pp_data_oe == !pp_dir, "R8 oe inverse of dir", pp_data_oe, !pp_dir);
    end
  end

  task automatic acc(input bit wr, input logic [2:0] off, input logic [1:0] sz,
                     input logic [31:0] wd, input int hold, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = off; req_size = sz; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == rd, "R9 response held", rsp_rdata, rd);
      chk(!req_ready, "R9 ready low until response taken", req_ready, 32'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic chk_wq(input string req, input int n, input logic [8:0] e0,
                        input logic [8:0] e1, input logic [8:0] e2, input logic [8:0] e3);
    logic [8:0] e[4];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    chk(wq.size() == n, req, wq.size(), n);
    for (int k = 0; k < n && k < wq.size(); k++) chk(wq[k] == e[k], req, wq[k], e[k]);
    wq.delete();
  endtask

  initial begin
    logic [31:0] r;
    int s0;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pp_naddrstb && pp_ndatastb && pp_nwrite && !pp_dir && pp_data_oe, "R1 idle pins",
        {pp_naddrstb, pp_ndatastb, pp_nwrite, pp_dir, pp_data_oe}, 32'h1D);
    acc(0, 3'd2, 0, 0, 0, r); chk(r == 32'h0C, "R1 control reset", r, 32'h0C);
    acc(0, 3'd1, 0, 0, 0, r); chk(r == 32'h01, "R1 status reset", r, 32'h01);
    // R6 status clear rules
    acc(1, 3'd1, 0, 32'hFE, 0, r); acc(0, 3'd1, 0, 0, 0, r);
    chk(r == 32'h01, "R6 bit0=0 keeps flag", r, 32'h01);
    acc(1, 3'd1, 0, 32'h01, 0, r); acc(0, 3'd1, 0, 0, 0, r);
    chk(r == 32'h00, "R6 bit0=1 clears flag", r, 32'h00);
    // R2 write rejected under reset control
    wq.delete(); s0 = n_stb;
    acc(1, 3'd3, 0, 32'h55, 0, r);
    chk(n_stb == s0, "R2 no strobe when gate closed", n_stb - s0, 0);
    chk_wq("R2 no byte when gate closed", 0, 0, 0, 0, 0);
    // R3 rejected reads return ones at width
    acc(0, 3'd4, 2, 0, 0, r); chk(r == 32'hFFFFFFFF, "R3 reject 4B", r, 32'hFFFFFFFF);
    acc(0, 3'd4, 1, 0, 0, r); chk(r == 32'h0000FFFF, "R3 reject 2B", r, 32'h0000FFFF);
    acc(0, 3'd4, 0, 0, 0, r); chk(r == 32'h000000FF, "R3 reject 1B", r, 32'hFF);
    acc(0, 3'd3, 2, 0, 0, r); chk(r == 32'h000000FF, "R3 reject addr", r, 32'hFF);
    chk(n_stb == s0, "R3 no strobe when gate closed", n_stb - s0, 0);
    // write mode
    acc(1, 3'd2, 0, 32'h04, 0, r);
    acc(1, 3'd3, 0, 32'h3C, 0, r);
    chk_wq("R4 address strobe write", 1, 9'h13C, 0, 0, 0);
    acc(1, 3'd4, 2, 32'h11223344, 0, r);
    chk_wq("R7 4B little-endian", 4, 9'h044, 9'h033, 9'h022, 9'h011);
    acc(1, 3'd4, 1, 32'hAABBCCDD, 0, r);
    chk_wq("R7 2B little-endian", 2, 9'h0DD, 9'h0CC, 0, 0);
    acc(1, 3'd2, 0, 32'h14, 0, r);
    acc(1, 3'd4, 0, 32'h5A, 0, r);
    chk_wq("R2 irq bit ignored by gate", 1, 9'h05A, 0, 0, 0);
    s0 = n_stb;
    acc(0, 3'd4, 1, 0, 0, r);
    chk(r == 32'h0000FFFF && n_stb == s0, "R3 read rejected in write mode", r, 32'h0000FFFF);
    // R8 direction switch ordering
    acc(1, 3'd2, 0, 32'h0C, 0, r);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_offset = 3'd2; req_wdata = 32'h24;
    @(negedge clk);
    req_valid = 1'b0;
    chk(pp_dir == 1'b1 && pp_ctl == 4'hC, "R8 dir first", {pp_dir, pp_ctl}, 32'h1C);
    @(negedge clk);
    chk(pp_dir == 1'b1 && pp_ctl == 4'h4, "R8 ctl after dir", {pp_dir, pp_ctl}, 32'h14);
    while (!rsp_valid) @(negedge clk);
    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
    // reads
    b = rd_idx;
    acc(0, 3'd4, 2, 0, 0, r);
    chk(r == {b + 8'd3, b + 8'd2, b + 8'd1, b} + 32'hA0A0A0A0, "R7 4B read lane order",
        r, {b + 8'd3, b + 8'd2, b + 8'd1, b} + 32'hA0A0A0A0);
    b = rd_idx;
    acc(0, 3'd3, 0, 0, 0, r);
    chk(r == {24'h0, 8'hA0 + b}, "R4 address read", r, {24'h0, 8'hA0 + b});
    s0 = n_stb;
    acc(1, 3'd4, 2, 32'hDEADBEEF, 0, r);
    chk(n_stb == s0, "R2 write rejected in read mode", n_stb - s0, 0);
    chk_wq("R2 write rejected in read mode", 0, 0, 0, 0, 0);
    // R5 timeout in strobe phase
    mode = 1; s0 = n_stb;
    acc(0, 3'd4, 2, 0, 0, r);
    chk(r == 32'hFFFFFFFF, "R5 read abandoned", r, 32'hFFFFFFFF);
    chk(n_stb == s0 + 1, "R5 remaining bytes abandoned", n_stb - s0, 1);
    acc(0, 3'd1, 0, 0, 0, r); chk(r == 32'h01, "R5 flag set", r, 32'h01);
    mode = 0;
    acc(1, 3'd1, 0, 32'h01, 0, r);
    // R5 timeout in release phase
    acc(1, 3'd2, 0, 32'h04, 0, r);
    mode = 2; s0 = n_stb;
    acc(1, 3'd4, 2, 32'h01020304, 0, r);
    chk(n_stb == s0 + 1, "R5 release timeout abandons rest", n_stb - s0, 1);
    chk_wq("R5 only first byte sent", 1, 9'h004, 0, 0, 0);
    acc(0, 3'd1, 0, 0, 0, r); chk(r == 32'h01, "R5 flag set in release", r, 32'h01);
    mode = 0;
    repeat (10) @(negedge clk);
    acc(1, 3'd1, 0, 32'h01, 0, r);
    acc(1, 3'd4, 0, 32'h77, 0, r);
    chk_wq("R5 recovers after clear", 1, 9'h077, 0, 0, 0);
    acc(0, 3'd1, 0, 0, 0, r); chk(r == 32'h00, "R6 flag stays clear", r, 32'h00);
    // R9 back-pressure on response
    acc(0, 3'd2, 0, 0, 4, r); chk(r == 32'h04, "R9 held control read", r, 32'h04);
    // R10 unused offsets
    acc(1, 3'd0, 0, 32'hFF, 0, r);
    acc(1, 3'd6, 0, 32'h00, 0, r);
    acc(0, 3'd0, 0, 0, 0, r); chk(r == 32'h0, "R10 offset 0 reads zero", r, 32'h0);
    acc(0, 3'd7, 0, 0, 0, r); chk(r == 32'h0, "R10 offset 7 reads zero", r, 32'h0);
    acc(0, 3'd2, 0, 0, 0, r); chk(r == 32'h04, "R10 control untouched", r, 32'h04);
    chk_wq("R10 no peripheral traffic", 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule